// File: doc/BRIEF.md
# AHB-Lite Byte-Lane SRAM Slave

This block is an AHB-Lite slave in front of on-chip RAM. The RAM is four independent byte-wide banks side by side, and together they form one 32-bit word. The bus address is a 16-bit byte address. Bits [WORD_AW+1:2] pick the word row, and that row selects all four banks at once. The slave samples the address phase and performs the access in the following data phase. A byte, halfword or word write enables only the banks picked by HSIZE and the low address bits. A read always returns the whole 32-bit word, and the master takes the lanes it addressed.

Reads are launched at the edge that accepts the address phase, so HRDATA is valid throughout the data phase with no wait state. Writes commit at the edge that ends the data phase, using the registered lane enables and HWDATA. Each bank resolves a read and a write to the same row in the same cycle in favour of the write. Because of this, a read issued right behind a write sees the new bytes. An unsupported transfer size gets the standard two-cycle ERROR response and touches no bank. The default of WORD_AW = 10 instantiates 4 KiB. Setting WORD_AW = 14 covers the full 0x0000 to 0xFFFF range.

Top module: `ahb_ram_slave`

## Requirements
- R1: During and right after reset, hreadyout_o is 1 and hresp_o is 0 (OKAY).
- R2: A word transfer (hsize_i = 2) writes all four byte lanes from hwdata_i. A later read of that word shows the data on hrdata_o during the data phase, which is the cycle after the address phase.
- R3: A byte transfer (hsize_i = 0) writes only one lane, chosen by haddr_i[1:0]: 0 gives bits 7:0, 1 gives 15:8, 2 gives 23:16 and 3 gives 31:24. The other three bytes of the word keep their value.
- R4: A halfword transfer (hsize_i = 1) writes bits 15:0 when haddr_i[1] = 0 and bits 31:16 when haddr_i[1] = 1. The other half keeps its value.
- R5: A read of any size returns the full 32-bit stored word on hrdata_o, not only the addressed lanes.
- R6: An address phase is taken when hsel_i, hready_i and htrans_i[1] are all 1. NONSEQ is 2'b10 and SEQ is 2'b11, and both start an access.
- R7: IDLE (2'b00), BUSY (2'b01) and any cycle with hsel_i = 0 cause no memory access. The data phase that follows responds OKAY with hreadyout_o = 1.
- R8: A read whose address phase falls in the data phase of a write to the same word returns the newly written bytes merged with the old ones.
- R9: An hsize_i of 3 or more gives two response cycles. The first has hresp_o = 1 and hreadyout_o = 0. The second has hresp_o = 1 and hreadyout_o = 1. No bank is written.
- R10: The word row is haddr_i[WORD_AW+1:2], and higher address bits are not decoded. With the default WORD_AW = 10, byte address 0x1040 names the same word as 0x0040.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsel_i | input | 1 | Slave select |
| haddr_i | input | 16 | Byte address |
| htrans_i | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| hwrite_i | input | 1 | 1 = write, 0 = read |
| hsize_i | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| hwdata_i | input | 32 | Write data, valid in the data phase |
| hready_i | input | 1 | Bus-level ready; previous transfer complete |
| hrdata_o | output | 32 | Read word, valid in the read data phase |
| hreadyout_o | output | 1 | This slave's ready |
| hresp_o | output | 1 | 0 OKAY, 1 ERROR |

## Verification
The assertions assume an AHB-Lite master that tracks this slave. hready_i equals hreadyout_o whenever this is the only slave. The master holds off a new address phase while hreadyout_o is low. A write's hwdata_i is stable in the cycle after its address phase. The bench wires hready_i straight to hreadyout_o. It changes the bus only at falling edges. During a data phase it drives IDLE, except where it deliberately overlaps a read with a write. During the low-ready error cycle it always drives IDLE.

// File: rtl/ahb_ram_pkg.sv
package ahb_ram_pkg;
  localparam int HADDR_W = 16;
  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;

  localparam logic [2:0] SZ_BYTE = 3'd0;
  localparam logic [2:0] SZ_HALF = 3'd1;
  localparam logic [2:0] SZ_WORD = 3'd2;

  typedef enum logic [1:0] {
    RSP_OK   = 2'd0,
    RSP_ERR1 = 2'd1,
    RSP_ERR2 = 2'd2
  } rsp_state_e;
endpackage

// File: rtl/ahb_ram_lane_dec.sv
module ahb_ram_lane_dec
  import ahb_ram_pkg::*;
(
  input  logic [2:0]       size_i,
  input  logic [1:0]       addr_lo_i,
  output logic [LANES-1:0] be_o,
  output logic             ok_o
);
  always_comb begin
    be_o = '0;
    ok_o = 1'b1;
    case (size_i)
      SZ_BYTE: be_o[addr_lo_i] = 1'b1;
      SZ_HALF: be_o = addr_lo_i[1] ? 4'b1100 : 4'b0011;
      SZ_WORD: be_o = '1;
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ahb_ram_bank.sv
module ahb_ram_bank #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];
  logic [7:0] rdata_q;

  // write-first on a same-row collision
  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_q <= (we_i && (waddr_i == raddr_i)) ? wdata_i : mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ahb_ram_slave.sv
module ahb_ram_slave
  import ahb_ram_pkg::*;
#(
  parameter int WORD_AW = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hsel_i,
  input  logic [HADDR_W-1:0] haddr_i,
  input  logic [1:0]         htrans_i,
  input  logic               hwrite_i,
  input  logic [2:0]         hsize_i,
  input  logic [DATA_W-1:0]  hwdata_i,
  input  logic               hready_i,
  output logic [DATA_W-1:0]  hrdata_o,
  output logic               hreadyout_o,
  output logic               hresp_o
);
  logic               accept;
  logic               sz_ok;
  logic [LANES-1:0]   ap_be;
  logic [WORD_AW-1:0] ap_widx;

  logic               dp_wr_q;
  logic [LANES-1:0]   dp_be_q;
  logic [WORD_AW-1:0] dp_widx_q;
  logic [LANES-1:0]   bank_we;
  logic               rd_en;

  rsp_state_e rsp_q, rsp_d;

  assign accept  = hsel_i & hready_i & htrans_i[1];
  assign ap_widx = haddr_i[WORD_AW+1:2];

  ahb_ram_lane_dec u_dec (
    .size_i   (hsize_i),
    .addr_lo_i(haddr_i[1:0]),
    .be_o     (ap_be),
    .ok_o     (sz_ok)
  );

  // address phase -> data phase register (writes only; reads launch now)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_wr_q   <= 1'b0;
      dp_be_q   <= '0;
      dp_widx_q <= '0;
    end else if (hready_i) begin
      dp_wr_q   <= accept & sz_ok & hwrite_i;
      dp_be_q   <= ap_be;
      dp_widx_q <= ap_widx;
    end
  end

  assign bank_we = {LANES{dp_wr_q & hready_i}} & dp_be_q;
  assign rd_en   = accept & sz_ok & ~hwrite_i;

  for (genvar l = 0; l < LANES; l++) begin : g_bank
    ahb_ram_bank #(.AW(WORD_AW)) u_bank (
      .clk_i  (clk_i),
      .we_i   (bank_we[l]),
      .waddr_i(dp_widx_q),
      .wdata_i(hwdata_i[8*l +: 8]),
      .re_i   (rd_en),
      .raddr_i(ap_widx),
      .rdata_o(hrdata_o[8*l +: 8])
    );
  end

  // two-cycle ERROR for unsupported sizes
  always_comb begin
    case (rsp_q)
      RSP_ERR1: rsp_d = RSP_ERR2;
      default:  rsp_d = (accept && !sz_ok) ? RSP_ERR1 : RSP_OK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsp_q <= RSP_OK;
    else         rsp_q <= rsp_d;
  end

  assign hreadyout_o = (rsp_q != RSP_ERR1);
  assign hresp_o     = (rsp_q != RSP_OK);

  // R9: low-ready error cycle is followed by the high-ready error cycle
  a_r9_err_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hresp_o && !hreadyout_o) |=> (hresp_o && hreadyout_o));

  // R9: an unsupported size never reaches the banks
  a_r9_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hsize_i > SZ_WORD) |=> (bank_we == '0));

  // R3: a byte write enables exactly one bank
  a_r3_one_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hwrite_i && hsize_i == SZ_BYTE) |=> (!hready_i || $countones(bank_we) == 1));

  // R4: a halfword write enables exactly two banks
  a_r4_two_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hwrite_i && hsize_i == SZ_HALF) |=> (!hready_i || $countones(bank_we) == 2));

  // R7: IDLE/BUSY get a zero-wait OKAY
  a_r7_idle_okay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsel_i && hready_i && hreadyout_o && !htrans_i[1]) |=> (hreadyout_o && !hresp_o));
endmodule

// File: tb/tb_ahb_ram_slave.sv
`timescale 1ns/1ps
module tb_ahb_ram_slave;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        hsel_i;
  logic [15:0] haddr_i;
  logic [1:0]  htrans_i;
  logic        hwrite_i;
  logic [2:0]  hsize_i;
  logic [31:0] hwdata_i;
  logic [31:0] hrdata_o;
  logic        hreadyout_o;
  logic        hresp_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ahb_ram_slave dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsel_i(hsel_i), .haddr_i(haddr_i),
    .htrans_i(htrans_i), .hwrite_i(hwrite_i), .hsize_i(hsize_i),
    .hwdata_i(hwdata_i), .hready_i(hreadyout_o), .hrdata_o(hrdata_o),
    .hreadyout_o(hreadyout_o), .hresp_o(hresp_o)
  );

  // fields: write[83] size[82:80] addr[79:64] data[63:32] expect[31:0]
  localparam int NV = 16;
  localparam logic [83:0] VEC [NV] = '{
    {1'b1, 3'd2, 16'h0010, 32'h11223344, 32'h0},
    {1'b0, 3'd2, 16'h0010, 32'h0,        32'h11223344},
    {1'b1, 3'd0, 16'h0011, 32'h0000AA00, 32'h0},
    {1'b0, 3'd2, 16'h0010, 32'h0,        32'h1122AA44},
    {1'b1, 3'd0, 16'h0013, 32'h55000000, 32'h0},
    {1'b1, 3'd0, 16'h0010, 32'h000000EE, 32'h0},
    {1'b1, 3'd0, 16'h0012, 32'h00770000, 32'h0},
    {1'b0, 3'd2, 16'h0010, 32'h0,        32'h5577AAEE},
    {1'b0, 3'd0, 16'h0011, 32'h0,        32'h5577AAEE},
    {1'b1, 3'd2, 16'h0020, 32'hDEADBEEF, 32'h0},
    {1'b1, 3'd1, 16'h0022, 32'h12340000, 32'h0},
    {1'b0, 3'd2, 16'h0020, 32'h0,        32'h1234BEEF},
    {1'b1, 3'd1, 16'h0020, 32'h00005678, 32'h0},
    {1'b0, 3'd2, 16'h0020, 32'h0,        32'h12345678},
    {1'b1, 3'd2, 16'h1040, 32'hCAFEF00D, 32'h0},
    {1'b0, 3'd2, 16'h0040, 32'h0,        32'hCAFEF00D}
  };

  function automatic string vec_req(int i);
    case (i)
      1:       return "R2";
      3, 7:    return "R3";
      8:       return "R5";
      11, 13:  return "R4";
      15:      return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_idle();
    hsel_i = 1'b0; htrans_i = 2'b00; hwrite_i = 1'b0; hsize_i = 3'd0; haddr_i = '0;
  endtask

  // one transfer: address phase, then data phase (sampled at its falling edge)
  task automatic xfer(input bit w, input logic [2:0] sz, input logic [15:0] a,
                      input logic [31:0] d, input logic [1:0] tr, input bit sel,
                      output logic [31:0] rd, output logic [1:0] rsp);
    @(negedge clk_i);
    hsel_i = sel; htrans_i = tr; hwrite_i = w; hsize_i = sz; haddr_i = a;
    @(negedge clk_i);
    bus_idle();
    hwdata_i = d;
    rd  = hrdata_o;
    rsp = {hreadyout_o, hresp_o};
  endtask

  // write, then a read whose address phase overlaps the write data phase
  task automatic b2b(input logic [2:0] wsz, input logic [15:0] wa, input logic [31:0] wd,
                     input logic [15:0] ra, input logic [31:0] exp, input string req);
    @(negedge clk_i);
    hsel_i = 1'b1; htrans_i = 2'b10; hwrite_i = 1'b1; hsize_i = wsz; haddr_i = wa;
    @(negedge clk_i);
    hwdata_i = wd;
    hwrite_i = 1'b0; hsize_i = 3'd2; haddr_i = ra;
    @(negedge clk_i);
    bus_idle();
    check(req, hrdata_o, exp);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [1:0]  rsp;
    rst_ni = 1'b0; hwdata_i = '0;
    bus_idle();
    repeat (2) @(negedge clk_i);
    check("R1 in reset", {30'd0, hreadyout_o, hresp_o}, 32'h2);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", {30'd0, hreadyout_o, hresp_o}, 32'h2);

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][83], VEC[i][82:80], VEC[i][79:64], VEC[i][63:32], 2'b10, 1'b1, rd, rsp);
      if (!VEC[i][83]) check(vec_req(i), rd, VEC[i][31:0]);
    end

    // R6: SEQ also starts an access
    xfer(1'b1, 3'd2, 16'h0060, 32'h01020304, 2'b11, 1'b1, rd, rsp);
    xfer(1'b0, 3'd2, 16'h0060, 32'h0, 2'b11, 1'b1, rd, rsp);
    check("R6 SEQ", rd, 32'h01020304);

    // R7: IDLE, BUSY and deselected writes leave memory untouched
    xfer(1'b1, 3'd2, 16'h0050, 32'h0BADC0DE, 2'b10, 1'b1, rd, rsp);
    xfer(1'b1, 3'd2, 16'h0050, 32'hFFFFFFFF, 2'b00, 1'b1, rd, rsp);
    check("R7 IDLE okay", {30'd0, rsp}, 32'h2);
    xfer(1'b1, 3'd2, 16'h0050, 32'hFFFFFFFF, 2'b01, 1'b1, rd, rsp);
    check("R7 BUSY okay", {30'd0, rsp}, 32'h2);
    xfer(1'b1, 3'd2, 16'h0050, 32'hFFFFFFFF, 2'b10, 1'b0, rd, rsp);
    xfer(1'b0, 3'd2, 16'h0050, 32'h0, 2'b10, 1'b1, rd, rsp);
    check("R7 no write", rd, 32'h0BADC0DE);

    // R8: back-to-back write then read
    b2b(3'd2, 16'h0070, 32'hA5A5A5A5, 16'h0070, 32'hA5A5A5A5, "R8 word");
    b2b(3'd0, 16'h0071, 32'h00003C00, 16'h0070, 32'hA5A53CA5, "R8 byte");

    // R9: unsupported size
    xfer(1'b1, 3'd2, 16'h0080, 32'h13579BDF, 2'b10, 1'b1, rd, rsp);
    xfer(1'b1, 3'd3, 16'h0080, 32'hFFFFFFFF, 2'b10, 1'b1, rd, rsp);
    check("R9 first cycle", {30'd0, rsp}, 32'h1);
    @(negedge clk_i);
    check("R9 second cycle", {30'd0, hreadyout_o, hresp_o}, 32'h3);
    @(negedge clk_i);
    check("R9 back to okay", {30'd0, hreadyout_o, hresp_o}, 32'h2);
    xfer(1'b0, 3'd2, 16'h0080, 32'h0, 2'b10, 1'b1, rd, rsp);
    check("R9 no write", rd, 32'h13579BDF);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule